// File: doc/BRIEF.md
# Protection-Key Rights Checker

This block decides whether a data access made from user mode may go ahead. Each page's page-table entry carries a small key number. A rights register holds two bits for each key: one forbids all access and one forbids writes. The block combines those key rights with the page's own read, write and execute bits, and with a flag that marks the page as a user page. The check is combinational. The block reports whether the access is allowed and, if it is not, which check refused it.

User code can rewrite the rights register through a simple write port, with no privileged step. A write changes the outcome of checks from the next clock cycle. Supervisor pages and instruction fetches are never subject to key rights. For those accesses only the page bits decide. When both the page bits and the key rights refuse an access, the page refusal is the one reported.

Top module: `pkr_checker`

## Requirements
- R1: After reset the rights register reads as all zeros on `rights_q`, so no key restricts anything.
- R2: A write (`rights_wr_en` high at a rising edge) loads all of `rights_wr_data` into the register at that edge. Checks made before the edge still use the old contents.
- R3: Key k is governed by bit 2k (access-disable) and bit 2k+1 (write-disable) of the rights register. The key input picks the pair, including the highest key.
- R4: On a user page, a set access-disable bit refuses both reads (`chk_kind`=0) and writes (`chk_kind`=1) with fault code 2.
- R5: On a user page, a set write-disable bit refuses writes with fault code 3 and leaves reads allowed.
- R6: If both bits of the key are set and the access is a write, the fault code is 2, not 3.
- R7: When `chk_user_page` is low, the key rights have no effect and only the page bits decide.
- R8: A fetch (`chk_kind[1]` set) ignores the key rights and is allowed exactly when `pte_x` is set.
- R9: If the page bit needed by the access is clear (`pte_r` for a read, `pte_w` for a write, `pte_x` for a fetch), the access is refused with fault code 1, even when a key fault also applies.
- R10: `chk_allow` is high exactly when the fault code is 0, the code for no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rights_wr_en | input | 1 | Write strobe for the rights register |
| rights_wr_data | input | 32 | New rights value |
| rights_q | output | 32 | Current rights register contents |
| chk_key | input | 4 | Key taken from the page-table entry |
| chk_user_page | input | 1 | Page is a user page |
| chk_kind | input | 2 | 0 read, 1 write, bit 1 set = fetch |
| pte_r | input | 1 | Page readable |
| pte_w | input | 1 | Page writable |
| pte_x | input | 1 | Page executable |
| chk_allow | output | 1 | Access allowed |
| chk_fault | output | 2 | 0 none, 1 page, 2 key access-disable, 3 key write-disable |

## Verification
The rights register is the only state in the block. A corrupted bit shows up as a wrong `rights_q` value in the cycle after the write. It also shows up in the very next check that uses that key's pair, where a user-page access gets the wrong allow or fault code. A fault in the selection or priority logic shows up in the same cycle as the check that exposes it. Examples are key 15 choosing the wrong pair, a write reporting 3 where 2 is due, or a key fault on a supervisor page or a fetch. For this reason the vectors cover every pair of fault sources that can occur together.

// File: rtl/pkr_pkg.sv
package pkr_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_PAGE   = 2'd1,
    FLT_KEY_AD = 2'd2,
    FLT_KEY_WD = 2'd3
  } fault_e;

  // access kind: bit 1 marks a fetch, otherwise bit 0 marks a write
  function automatic logic kind_is_fetch(input logic [1:0] kind);
    return kind[1];
  endfunction

  function automatic logic kind_is_write(input logic [1:0] kind);
    return !kind[1] && kind[0];
  endfunction

  // page bits needed by the access kind
  function automatic logic page_permits(input logic [1:0] kind,
                                        input logic r, input logic w, input logic x);
    if (kind_is_fetch(kind)) return x;
    if (kind_is_write(kind)) return w;
    return r;
  endfunction

  // key rights are consulted only for data accesses to user pages
  function automatic logic key_applies(input logic [1:0] kind, input logic user_page);
    return user_page && !kind_is_fetch(kind);
  endfunction
endpackage

// File: rtl/pkr_rights_reg.sv
module pkr_rights_reg #(
  parameter int NUM_KEYS = 16,
  localparam int RW = 2 * NUM_KEYS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [RW-1:0]       wr_data,
  output logic [RW-1:0]       rights_q,
  output logic [NUM_KEYS-1:0] ad_vec,
  output logic [NUM_KEYS-1:0] wd_vec
);
  always_ff @(posedge clk) begin
    if (!rst_n)     rights_q <= '0;
    else if (wr_en) rights_q <= wr_data;
  end

  // split the register into per-key bit pairs
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_split
    assign ad_vec[k] = rights_q[2*k];
    assign wd_vec[k] = rights_q[2*k+1];
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_WR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_en) |-> rights_q == $past(wr_data)); // R2
  AST_NO_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(wr_en) |-> $stable(rights_q)); // R2
endmodule

// File: rtl/pkr_key_select.sv
module pkr_key_select #(
  parameter int NUM_KEYS = 16,
  localparam int KW = $clog2(NUM_KEYS)
) (
  input  logic [NUM_KEYS-1:0] ad_vec,
  input  logic [NUM_KEYS-1:0] wd_vec,
  input  logic [KW-1:0]       key,
  output logic                key_ad,
  output logic                key_wd
);
  // one-hot decode of the key, then AND-OR reduction
  logic [NUM_KEYS-1:0] key_hot;
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_dec
    assign key_hot[k] = (key == KW'(k));
  end

  assign key_ad = |(key_hot & ad_vec);
  assign key_wd = |(key_hot & wd_vec);
endmodule

// File: rtl/pkr_fault_arb.sv
module pkr_fault_arb
  import pkr_pkg::*;
(
  input  logic       page_ok,
  input  logic       ad_hit,
  input  logic       wd_hit,
  output logic [1:0] fault
);
  // priority: page, then access-disable, then write-disable
  always_comb begin
    if (!page_ok)    fault = FLT_PAGE;
    else if (ad_hit) fault = FLT_KEY_AD;
    else if (wd_hit) fault = FLT_KEY_WD;
    else             fault = FLT_NONE;
  end
endmodule

// File: rtl/pkr_checker.sv
module pkr_checker
  import pkr_pkg::*;
#(
  parameter int NUM_KEYS = 16,
  localparam int KW = $clog2(NUM_KEYS),
  localparam int RW = 2 * NUM_KEYS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rights_wr_en,
  input  logic [RW-1:0] rights_wr_data,
  output logic [RW-1:0] rights_q,
  input  logic [KW-1:0] chk_key,
  input  logic          chk_user_page,
  input  logic [1:0]    chk_kind,
  input  logic          pte_r,
  input  logic          pte_w,
  input  logic          pte_x,
  output logic          chk_allow,
  output logic [1:0]    chk_fault
);
  logic [NUM_KEYS-1:0] ad_vec, wd_vec;
  logic key_ad, key_wd;

  pkr_rights_reg #(.NUM_KEYS(NUM_KEYS)) u_rights (
    .clk(clk), .rst_n(rst_n), .wr_en(rights_wr_en), .wr_data(rights_wr_data),
    .rights_q(rights_q), .ad_vec(ad_vec), .wd_vec(wd_vec));

  pkr_key_select #(.NUM_KEYS(NUM_KEYS)) u_sel (
    .ad_vec(ad_vec), .wd_vec(wd_vec), .key(chk_key),
    .key_ad(key_ad), .key_wd(key_wd));

  // named events for the assertions
  logic page_ok, key_on, ad_hit, wd_hit;
  assign page_ok = page_permits(chk_kind, pte_r, pte_w, pte_x);
  assign key_on  = key_applies(chk_kind, chk_user_page);
  assign ad_hit  = key_on && key_ad;
  assign wd_hit  = key_on && key_wd && kind_is_write(chk_kind);

  pkr_fault_arb u_arb (.page_ok(page_ok), .ad_hit(ad_hit), .wd_hit(wd_hit), .fault(chk_fault));

  assign chk_allow = page_ok && !ad_hit && !wd_hit;

  AST_ALLOW_IFF_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_allow == (chk_fault == FLT_NONE)); // R10
  AST_SUPV_NO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_user_page |-> chk_fault inside {FLT_NONE, FLT_PAGE}); // R7
  AST_FETCH_NO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    chk_kind[1] |-> chk_allow == pte_x); // R8
  AST_PAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !page_ok |-> chk_fault == FLT_PAGE); // R9
  AST_AD_OVER_WD: assert property (@(posedge clk) disable iff (!rst_n)
    ad_hit && page_ok |-> chk_fault == FLT_KEY_AD); // R6
endmodule

// File: tb/pkr_checker_bench.sv
module pkr_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0, rights_q;
  logic [3:0] key = '0;
  logic user = 1'b0;
  logic [1:0] kind = '0;
  logic pr = 1'b0, pw = 1'b0, px = 1'b0;
  logic allow;
  logic [1:0] fault;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkr_checker u_pkr_checker (
    .clk(clk), .rst_n(rst_n), .rights_wr_en(wr_en), .rights_wr_data(wr_data),
    .rights_q(rights_q), .chk_key(key), .chk_user_page(user), .chk_kind(kind),
    .pte_r(pr), .pte_w(pw), .pte_x(px), .chk_allow(allow), .chk_fault(fault));

  // rights: key1 AD, key2 WD, key3 both, key15 AD
  localparam logic [31:0] RIGHTS = 32'h4000_00E4;
  // {key, user, kind, rwx, exp_allow, exp_fault}
  localparam logic [12:0] VEC [NV] = '{
    {4'd0, 1'b1, 2'd0, 3'b110, 1'b1, 2'd0},  // R3 unrestricted key
    {4'd1, 1'b1, 2'd0, 3'b110, 1'b0, 2'd2},  // R4 AD read
    {4'd1, 1'b1, 2'd1, 3'b110, 1'b0, 2'd2},  // R4 AD write
    {4'd2, 1'b1, 2'd0, 3'b110, 1'b1, 2'd0},  // R5 WD read ok
    {4'd2, 1'b1, 2'd1, 3'b110, 1'b0, 2'd3},  // R5 WD write
    {4'd3, 1'b1, 2'd1, 3'b110, 1'b0, 2'd2},  // R6 both
    {4'd1, 1'b0, 2'd0, 3'b110, 1'b1, 2'd0},  // R7 supervisor
    {4'd2, 1'b0, 2'd1, 3'b110, 1'b1, 2'd0},  // R7 supervisor write
    {4'd1, 1'b1, 2'd0, 3'b010, 1'b0, 2'd1},  // R9 page over key
    {4'd2, 1'b1, 2'd1, 3'b100, 1'b0, 2'd1},  // R9 page over WD
    {4'd1, 1'b1, 2'd2, 3'b001, 1'b1, 2'd0},  // R8 fetch ignores key
    {4'd0, 1'b1, 2'd3, 3'b110, 1'b0, 2'd1},  // R8 fetch no x
    {4'd15,1'b1, 2'd0, 3'b100, 1'b0, 2'd2},  // R3 top key
    {4'd14,1'b1, 2'd1, 3'b110, 1'b1, 2'd0},  // R3 neighbour key
    {4'd0, 1'b0, 2'd0, 3'b000, 1'b0, 2'd1}   // R9 supervisor page bits
  };

  task automatic check(input string req, input logic a, input logic [1:0] f,
                       input logic ea, input logic [1:0] ef);
    checks++;
    if (a !== ea || f !== ef) begin
      errors++;
      $display("FAIL %s allow=%0b fault=%0d expected allow=%0b fault=%0d", req, a, f, ea, ef);
    end
    // R10 relation at the ports
    checks++;
    if (a !== (f == 2'd0)) begin
      errors++;
      $display("FAIL R10 allow=%0b fault=%0d expected allow=%0b", a, f, (f == 2'd0));
    end
  endtask

  task automatic check_word(input string req, input logic [31:0] v, input logic [31:0] e);
    checks++;
    if (v !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, v, e);
    end
  endtask

  task automatic apply(input logic [3:0] k, input logic u, input logic [1:0] kd, input logic [2:0] p);
    key = k; user = u; kind = kd; {pr, pw, px} = p;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check_word("R1 reset value", rights_q, 32'h0);
    apply(4'd1, 1'b1, 2'd1, 3'b110); #1;
    check("R1 no restriction after reset", allow, fault, 1'b1, 2'd0);

    // program table rights
    @(negedge clk); wr_data = RIGHTS; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; #1;
    check_word("R2 readback", rights_q, RIGHTS);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][12:9], VEC[i][8], VEC[i][7:6], VEC[i][5:3]); #1;
      check($sformatf("vector %0d R3-table", i), allow, fault, VEC[i][2], VEC[i][1:0]);
      @(negedge clk);
    end

    // R2: new value only after the edge
    apply(4'd4, 1'b1, 2'd0, 3'b110);
    wr_data = RIGHTS | 32'h0000_0100; wr_en = 1'b1; #1;
    check("R2 old rights before edge", allow, fault, 1'b1, 2'd0);
    @(negedge clk); wr_en = 1'b0; #1;
    check("R2 new rights after edge", allow, fault, 1'b0, 2'd2);
    check_word("R2 readback after write", rights_q, RIGHTS | 32'h0000_0100);

    // R5 write-disable on key 15 only, key 15 AD cleared
    @(negedge clk); wr_data = 32'h8000_0000; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    apply(4'd15, 1'b1, 2'd1, 3'b110); #1;
    check("R5 key15 WD write", allow, fault, 1'b0, 2'd3);
    apply(4'd15, 1'b1, 2'd0, 3'b110); #1;
    check("R5 key15 WD read", allow, fault, 1'b1, 2'd0);
    apply(4'd1, 1'b1, 2'd1, 3'b110); #1;
    check("R4 key1 cleared", allow, fault, 1'b1, 2'd0);

    // R1 reset clears again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    check_word("R1 reset clears", rights_q, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule